// File: doc/BRIEF.md
# Banked Video Memory Address Mapper

This block places a small set of separately configured video RAM banks onto the address space a processor sees. Each bank holds an 8-bit control register that selects three things. One bit turns the bank on. A master-select code chooses which region the bank serves. A two-bit offset places the bank within that region. An access names a region and a byte address inside it. Every enabled bank whose window covers that address takes part in the access.

Windows may overlap, so there is no single winner. A read returns the bitwise OR of the halfwords from all banks that hit, and an address with no hit reads as zero. A write stores the same halfword into every bank that hits, and a write with no hit is dropped. Reads are combinational from the registered bank arrays. Writes and control updates take effect at the next clock edge.

There are two bank families. Large banks serve the texture region or the second-processor window. Small banks serve the background region or the object region. Each family computes its base address with its own formula.

Top module: `vmap_core`

## Requirements
- R1: After reset every control register is zero (all banks disabled) and all bank storage is zero, so every read in every region returns 0.
- R2: Control register bits: bit 7 is the enable, bits [4:3] are the offset, bits [2:0] are the master-select. cfg_sel picks the register written, with indices 0 and 1 for the large banks and 2 and 3 for the small banks. A bank whose enable is clear never hits.
- R3: Region codes on acc_region are 0 background, 1 object, 2 texture and 3 second-processor. A small bank hits only in background when its master-select is 1, and only in object when it is 2. A large bank hits in neither region.
- R4: A small bank's base is offset bit 0 × SMALL_BYTES plus offset bit 1 × 4 × SMALL_BYTES. Its window spans SMALL_BYTES from that base.
- R5: A large bank with master-select 3 hits in the texture region, with base equal to offset × LARGE_BYTES and a window of LARGE_BYTES.
- R6: A large bank with master-select 2 hits in the second-processor region, with base equal to offset bit 0 × LARGE_BYTES. Offset bit 1 is ignored.
- R7: acc_rdata is the bitwise OR of the halfwords of all hitting banks, and is 0 when no bank hits.
- R8: A write stores acc_wdata into every hitting bank. A write with no hit changes no bank.
- R9: Inside a bank, the halfword is chosen by the address bits below the bank size, with bit 0 ignored.
- R10: acc_rdata follows acc_region and acc_addr with no clock edge. A control write and a data access in the same cycle use the control value held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | SEL_W | Index of the bank control register to write |
| cfg_wdata | input | 8 | Control value: enable, offset, master-select |
| acc_region | input | 2 | Region of the data access |
| acc_addr | input | ADDR_W | Byte address within the region |
| acc_we | input | 1 | Data write strobe |
| acc_wdata | input | DATA_W | Halfword to write |
| acc_rdata | output | DATA_W | OR of the halfwords from all hitting banks |

## Verification
A control write and a data write can fall in the same clock edge. In that case the mapping in force before the edge must decide which banks take the data. The bench provokes this by disabling a small bank in the same cycle as a write to its window. It then re-enables the bank and reads the address back, and expects the written halfword, not zero. It also remaps two small banks onto one window, checks that the read is the OR of both, and then checks that a single write overwrites both.

// File: rtl/vmap_pkg.sv
package vmap_pkg;

    localparam logic [1:0] RG_BG  = 2'd0;
    localparam logic [1:0] RG_OBJ = 2'd1;
    localparam logic [1:0] RG_TEX = 2'd2;
    localparam logic [1:0] RG_SUB = 2'd3;

    localparam logic [2:0] MS_BG  = 3'd1;
    localparam logic [2:0] MS_OBJ = 3'd2;
    localparam logic [2:0] MS_SUB = 3'd2;
    localparam logic [2:0] MS_TEX = 3'd3;

    typedef struct packed {
        logic       en;
        logic [1:0] rsv;
        logic [1:0] off;
        logic [2:0] mst;
    } ctrl_t;

endpackage

// File: rtl/vmap_bank.sv
module vmap_bank
    import vmap_pkg::*;
#(
    parameter int BYTES  = 64,
    parameter bit SMALL  = 1'b1,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        region,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = $clog2(DATA_W / 8);
    localparam int WORDS  = BYTES / (DATA_W / 8);
    localparam int OFF_W  = $clog2(BYTES);
    localparam int IDX_W  = OFF_W - LANE_W;
    localparam int WIDE   = ADDR_W + 4;

    typedef struct packed {
        ctrl_t                         ctrl;
        logic [WORDS-1:0][DATA_W-1:0]  mem;
    } st_t;

    st_t              st_d, st_q;
    logic             sel_ok;
    logic [WIDE-1:0]  base;
    logic [WIDE-1:0]  a_w;
    logic [IDX_W-1:0] idx;

    always_comb begin
        sel_ok = 1'b0;
        base   = '0;
        if (SMALL) begin
            sel_ok = (st_q.ctrl.mst == MS_BG  && region == RG_BG) ||
                     (st_q.ctrl.mst == MS_OBJ && region == RG_OBJ);
            if (st_q.ctrl.off[0]) base = base + WIDE'(BYTES);
            if (st_q.ctrl.off[1]) base = base + WIDE'(4 * BYTES);
        end else begin
            if (st_q.ctrl.mst == MS_TEX && region == RG_TEX) begin
                sel_ok = 1'b1;
                base   = WIDE'(st_q.ctrl.off) * WIDE'(BYTES);
            end else if (st_q.ctrl.mst == MS_SUB && region == RG_SUB) begin
                sel_ok = 1'b1;
                base   = st_q.ctrl.off[0] ? WIDE'(BYTES) : '0;
            end
        end
        a_w   = WIDE'(addr);
        idx   = addr[OFF_W-1:LANE_W];
        hit   = st_q.ctrl.en && sel_ok && (a_w >= base) && (a_w < base + WIDE'(BYTES));
        rdata = hit ? st_q.mem[idx] : '0;

        st_d = st_q;
        if (cfg_we)
            st_d.ctrl = ctrl_t'(cfg_wdata);
        if (wr_en && hit)
            st_d.mem[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/vmap_or_merge.sv
module vmap_or_merge #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++)
            dout = dout | din[i];
    end
endmodule

// File: rtl/vmap_core.sv
module vmap_core
    import vmap_pkg::*;
#(
    parameter int NUM_LARGE   = 2,
    parameter int NUM_SMALL   = 2,
    parameter int LARGE_BYTES = 256,
    parameter int SMALL_BYTES = 64,
    parameter int DATA_W      = 16,
    parameter int NUM_BANKS   = NUM_LARGE + NUM_SMALL,
    parameter int SEL_W       = $clog2(NUM_BANKS),
    parameter int ADDR_W      = $clog2(4 * LARGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        acc_region,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_we,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata
);
    logic [NUM_BANKS-1:0]             bank_cfg_we;
    logic [NUM_BANKS-1:0]             bank_hit;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++)
            bank_cfg_we[i] = cfg_we && (cfg_sel == SEL_W'(i));
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        if (g < NUM_LARGE) begin : g_large
            vmap_bank #(
                .BYTES(LARGE_BYTES), .SMALL(1'b0), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .cfg_we(bank_cfg_we[g]), .cfg_wdata(cfg_wdata),
                .region(acc_region), .addr(acc_addr), .wr_en(acc_we), .wdata(acc_wdata),
                .hit(bank_hit[g]), .rdata(bank_rd[g])
            );
        end else begin : g_small
            vmap_bank #(
                .BYTES(SMALL_BYTES), .SMALL(1'b1), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .cfg_we(bank_cfg_we[g]), .cfg_wdata(cfg_wdata),
                .region(acc_region), .addr(acc_addr), .wr_en(acc_we), .wdata(acc_wdata),
                .hit(bank_hit[g]), .rdata(bank_rd[g])
            );
        end
    end

    vmap_or_merge #(.N(NUM_BANKS), .W(DATA_W)) u_merge (
        .din(bank_rd), .dout(acc_rdata)
    );

endmodule

// File: rtl/vmap_core_chk.sv
module vmap_core_chk
    import vmap_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_LARGE = 2,
    parameter int SEL_W     = 2,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [SEL_W-1:0]     cfg_sel,
    input logic                 cfg_en,
    input logic [1:0]           acc_region,
    input logic [ADDR_W-1:0]    acc_addr,
    input logic                 acc_we,
    input logic [DATA_W-1:0]    acc_wdata,
    input logic [DATA_W-1:0]    acc_rdata,
    input logic [NUM_BANKS-1:0] bank_hit
);
    p_nohit_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_hit == '0) |-> (acc_rdata == '0));

    p_disabled_nohit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en) |=> !bank_hit[$past(cfg_sel)]);

    p_large_not_bgobj_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_region == RG_BG || acc_region == RG_OBJ) |-> (bank_hit[NUM_LARGE-1:0] == '0));

    p_small_not_texsub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_region == RG_TEX || acc_region == RG_SUB) |-> (bank_hit[NUM_BANKS-1:NUM_LARGE] == '0));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !cfg_we && bank_hit != '0) |=>
        (!($stable(acc_addr) && $stable(acc_region)) || acc_rdata == $past(acc_wdata)));

endmodule

bind vmap_core vmap_core_chk #(
    .NUM_BANKS(NUM_BANKS), .NUM_LARGE(NUM_LARGE), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_wdata[7]),
    .acc_region(acc_region), .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .bank_hit(bank_hit)
);

// File: tb/vmap_core_tb.sv
module vmap_core_tb;
    localparam logic [1:0] BG = 2'd0, OBJ = 2'd1, TEX = 2'd2, SUB = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [1:0]  acc_region = '0;
    logic [9:0]  acc_addr = '0;
    logic        acc_we = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vmap_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_region(acc_region), .acc_addr(acc_addr), .acc_we(acc_we),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  region;
        logic [9:0]  addr;
        logic [15:0] wdata;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, TEX, 10'h100, 16'h1111, 16'h1111}, // R5 bank0 base 256
        '{1'b0, TEX, 10'h000, 16'h0000, 16'h0000}, // R5 below window
        '{1'b0, TEX, 10'h200, 16'h0000, 16'h0000}, // R5 above window
        '{1'b1, SUB, 10'h004, 16'h2222, 16'h2222}, // R6 offset bit1 ignored
        '{1'b0, SUB, 10'h104, 16'h0000, 16'h0000}, // R6 past window
        '{1'b1, BG,  10'h142, 16'h3333, 16'h3333}, // R4 small base 320
        '{1'b0, BG,  10'h143, 16'h0000, 16'h3333}, // R9 bit0 ignored
        '{1'b0, OBJ, 10'h142, 16'h0000, 16'h0000}, // R3 wrong region
        '{1'b0, BG,  10'h180, 16'h0000, 16'h0000}, // R4 past small window
        '{1'b1, BG,  10'h002, 16'h4444, 16'h4444}, // R3 bank3 base 0
        '{1'b1, BG,  10'h064, 16'h5555, 16'h0000}, // R8 no hit dropped
        '{1'b0, TEX, 10'h100, 16'h0000, 16'h1111}  // R7 earlier data intact
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic dat_write(input logic [1:0] rg, input logic [9:0] a, input logic [15:0] v);
        @(negedge clk);
        acc_we = 1'b1; acc_region = rg; acc_addr = a; acc_wdata = v;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] rg, input logic [9:0] a,
                            input logic [15:0] exp);
        @(negedge clk);
        acc_region = rg; acc_addr = a;
        #1;
        check(req, acc_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything disabled and cleared
        rd_check("R1", BG,  10'h000, 16'h0000);
        rd_check("R1", OBJ, 10'h000, 16'h0000);
        rd_check("R1", TEX, 10'h000, 16'h0000);
        rd_check("R1", SUB, 10'h000, 16'h0000);

        // R2 layout: en bit7, off [4:3], mst [2:0]
        cfg_write(2'd0, 8'h8B); // large, texture, off 1
        cfg_write(2'd1, 8'h92); // large, second proc, off 2
        cfg_write(2'd2, 8'h99); // small, background, off 3
        cfg_write(2'd3, 8'h81); // small, background, off 0

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].we) dat_write(VECS[i].region, VECS[i].addr, VECS[i].wdata);
            rd_check($sformatf("vector %0d", i), VECS[i].region, VECS[i].addr, VECS[i].exp);
        end

        // R7: overlap of both small banks, OR of their halfwords
        cfg_write(2'd2, 8'h81);
        rd_check("R7", BG, 10'h002, 16'h7777);
        // R8: one write reaches both hitting banks
        dat_write(BG, 10'h002, 16'h00F0);
        rd_check("R8", BG, 10'h002, 16'h00F0);
        cfg_write(2'd3, 8'h82);
        rd_check("R3", OBJ, 10'h002, 16'h00F0);
        rd_check("R8", BG,  10'h002, 16'h00F0);

        // R10: config write and data write in one cycle use old mapping
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'h01;
        acc_we = 1'b1; acc_region = BG; acc_addr = 10'h004; acc_wdata = 16'hABCD;
        @(negedge clk);
        cfg_we = 1'b0; acc_we = 1'b0;
        rd_check("R2", BG, 10'h004, 16'h0000);
        cfg_write(2'd2, 8'h81);
        rd_check("R10", BG, 10'h004, 16'hABCD);

        // R10: combinational read, address change with no edge
        @(negedge clk);
        acc_region = TEX; acc_addr = 10'h100;
        #1 check("R10", acc_rdata, 16'h1111);
        acc_addr = 10'h000;
        #1 check("R10", acc_rdata, 16'h0000);

        // R2: master-select mismatch on a large bank never hits
        cfg_write(2'd0, 8'h89);
        rd_check("R2", TEX, 10'h100, 16'h0000);
        rd_check("R2", BG,  10'h100, 16'h0000);

        // R5: offset 0 puts large bank at texture base 0
        cfg_write(2'd0, 8'h83);
        rd_check("R5", TEX, 10'h000, 16'h1111);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule